// File: doc/BRIEF.md
# Grouped External Interrupt Controller

This block watches 28 external interrupt lines and gives a primary interrupt controller four summary requests. Each line goes through a two-flop synchroniser. A programmable detector then fires on a low level, a high level, a falling edge, a rising edge or either edge. A detection latches a per-line pending bit. A per-line mask bit then gates that bit on its way to the summary requests. Each summary request is the OR of the unmasked pending bits over a fixed, uneven range of lines.

Software reaches the block through a small single-cycle register bus. There are two trigger-configuration words, a mask word and a pending word. Two neighbouring lines share one trigger field. Pending bits are cleared by writing ones. A level-type line keeps re-arming its pending bit for as long as its level is present, so a clear only sticks after the line has gone inactive.

Top module: `ext_irq_grouper`

## Requirements
- R1: Trigger fields are 3 bits wide, and lines 2k and 2k+1 share one field. Lines 0..15 use the word at address 0, and lines 16..27 use the word at address 1. The field for line n sits at bit ((n mod 16)/2)*4 of its word.
- R2: Field encoding: 000 low level, 001 high level, 01x falling edge, 10x rising edge, 11x either edge.
- R3: A level-type line sets its pending bit on every clock while the synchronised level is active. A clear written during that time has no lasting effect.
- R4: An input change reaches the pending bit after passing two synchroniser stages. Edges are found by comparing the synchronised value with the value one clock earlier. A change that is set up before clock edge 1 shows in the pending word after edge 3.
- R5: The pending word is at address 3, with bit n for line n. Writing 1 to a bit clears it and writing 0 leaves it unchanged. If a detection and a clear fall on the same bit in the same cycle, the bit stays set.
- R6: The mask word is at address 2, with bit n for line n. A 1 blocks the line from the summary outputs, and a 0 passes it. Masking never stops a line from becoming pending.
- R7: grp_irq[0..3] are each the OR of pending AND NOT mask over lines 0..3, 4..11, 12..19 and 20..27 respectively.
- R8: Reset gives all configuration fields 000, all mask bits 1, all pending bits 0 and all summary outputs 0.
- R9: Reads return 0 in every unused bit: bit 3 of each nibble, bits 31:24 of address 1, and bits 31:28 of addresses 2 and 3. Writes to unused bits, which includes fields for lines above 27, are ignored.
- R10: bus_rdata shows the word selected by bus_addr in the same cycle, with no wait state. A write with bus_wr high takes effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 28 | External interrupt lines, asynchronous |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Word select: 0 cfg lo, 1 cfg hi, 2 mask, 3 pending |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected word |
| grp_irq | output | 4 | Summary requests for the four line groups |

## Verification
The two functions that can land in the same cycle are a fresh detection setting a pending bit and a software write-1 clearing that same bit. The bench provokes this by holding a high-level line active while it writes a clear to its pending bit, and again by writing random clears while random edges arrive. It judges the outcome against a behavioural model in which set wins. A mask write that coincides with a new pending bit is also exercised, and the summary outputs are compared on every clock.

// File: rtl/ext_irq_grouper.sv
module ext_irq_grouper #(
  parameter int LINES = 28,
  parameter int DW    = 32,
  parameter int AW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] irq_in,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic [3:0]       grp_irq
);
  localparam int FIELDS = (LINES + 1) / 2;
  localparam int LO_F   = 8;
  localparam int HI_TOP = 4 * (FIELDS - LO_F);
  localparam int G1 = 4, G2 = 12, G3 = 20;
  localparam logic [AW-1:0] A_CFG0 = AW'(0);
  localparam logic [AW-1:0] A_CFG1 = AW'(1);
  localparam logic [AW-1:0] A_MASK = AW'(2);
  localparam logic [AW-1:0] A_PEND = AW'(3);

  logic [LINES-1:0] s1, s2, s3, mask_q, pend_q, trig, clr, act;
  logic [2:0]       cfg [FIELDS];
  logic [DW-1:0]    cfg0_v, cfg1_v;
  logic             unused_ok;

  function automatic logic hit(input logic [2:0] f, input logic cur, input logic prv);
    if (f == 3'b000)       return !cur;
    else if (f == 3'b001)  return cur;
    else if (f[2:1] == 2'b01) return prv & !cur;
    else if (f[2:1] == 2'b10) return !prv & cur;
    else                   return prv ^ cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, s3} <= '0;
    else        {s1, s2, s3} <= {irq_in, s1, s2};

  for (genvar k = 0; k < FIELDS; k++) begin : g_fld
    if (k < LO_F) begin : g_lo
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) cfg[k] <= '0;
        else if (bus_wr && bus_addr == A_CFG0) cfg[k] <= bus_wdata[4*k +: 3];
      assign cfg0_v[4*k +: 4] = {1'b0, cfg[k]};
    end else begin : g_hi
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) cfg[k] <= '0;
        else if (bus_wr && bus_addr == A_CFG1) cfg[k] <= bus_wdata[4*(k-LO_F) +: 3];
      assign cfg1_v[4*(k-LO_F) +: 4] = {1'b0, cfg[k]};
    end
  end
  assign cfg1_v[DW-1:HI_TOP] = '0;

  for (genvar n = 0; n < LINES; n++) begin : g_line
    assign trig[n] = hit(cfg[n/2], s2[n], s3[n]);
    AST_TRIG_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      trig[n] |=> pend_q[n]); // R3
    AST_PEND_ONLY_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend_q[n]) |-> $past(bus_wr && bus_addr == A_PEND && bus_wdata[n])); // R5
  end

  assign clr = (bus_wr && bus_addr == A_PEND) ? bus_wdata[LINES-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mask_q <= '1;
      pend_q <= '0;
    end else begin
      if (bus_wr && bus_addr == A_MASK) mask_q <= bus_wdata[LINES-1:0];
      pend_q <= (pend_q & ~clr) | trig;
    end

  assign act = pend_q & ~mask_q;
  assign grp_irq = {|act[LINES-1:G3], |act[G3-1:G2], |act[G2-1:G1], |act[G1-1:0]};

  always_comb
    case (bus_addr)
      A_CFG0:  bus_rdata = cfg0_v;
      A_CFG1:  bus_rdata = cfg1_v;
      A_MASK:  bus_rdata = {{(DW-LINES){1'b0}}, mask_q};
      default: bus_rdata = {{(DW-LINES){1'b0}}, pend_q};
    endcase

  assign unused_ok = ^bus_wdata[DW-1:LINES];

  AST_MASK_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_wr && bus_addr == A_MASK) |-> $stable(mask_q)); // R6
  AST_GRP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == '0) |-> (grp_irq == 4'b0)); // R7
  AST_CFG1_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_CFG1) |-> (bus_rdata[DW-1:HI_TOP] == '0)); // R9
endmodule

// File: tb/sim_ext_irq_grouper.sv
module sim_ext_irq_grouper;
  logic        clk = 0, rst_n = 0, bus_wr = 0;
  logic [27:0] irq_in = '1;
  logic [1:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [3:0]  grp_irq;
  int tests = 0, fails = 0;
  string tag = "R8";

  ext_irq_grouper u0 (.clk, .rst_n, .irq_in, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata, .grp_irq);

  always #2 clk = ~clk;

  logic [2:0]  mcfg [14];
  logic [27:0] mmask, mpend, q1, q2, q3, mt, mclr;

  function automatic logic fire(input logic [2:0] f, input logic c, input logic p);
    case (f)
      3'd0: return !c;
      3'd1: return c;
      3'd2, 3'd3: return p && !c;
      3'd4, 3'd5: return !p && c;
      default: return p != c;
    endcase
  endfunction

  function automatic logic [31:0] mread(input logic [1:0] a);
    logic [31:0] v = 0;
    if (a == 0) for (int k = 0; k < 8; k++) v[4*k +: 3] = mcfg[k];
    else if (a == 1) for (int k = 8; k < 14; k++) v[4*(k-8) +: 3] = mcfg[k];
    else if (a == 2) v[27:0] = mmask;
    else v[27:0] = mpend;
    return v;
  endfunction

  function automatic logic [3:0] mgrp();
    logic [27:0] x = mpend & ~mmask;
    return {|x[27:20], |x[19:12], |x[11:4], |x[3:0]};
  endfunction

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int k = 0; k < 14; k++) mcfg[k] = 0;
      mmask = '1; mpend = 0; q1 = 0; q2 = 0; q3 = 0;
    end else begin
      for (int n = 0; n < 28; n++) mt[n] = fire(mcfg[n/2], q2[n], q3[n]);
      mclr = (bus_wr && bus_addr == 3) ? bus_wdata[27:0] : 0;
      mpend = (mpend & ~mclr) | mt;
      if (bus_wr && bus_addr == 0) for (int k = 0; k < 8; k++) mcfg[k] = bus_wdata[4*k +: 3];
      if (bus_wr && bus_addr == 1) for (int k = 8; k < 14; k++) mcfg[k] = bus_wdata[4*(k-8) +: 3];
      if (bus_wr && bus_addr == 2) mmask = bus_wdata[27:0];
      q3 = q2; q2 = q1; q1 = irq_in;
    end

  always @(negedge clk) begin
    tests += 2;
    if (bus_rdata !== mread(bus_addr)) begin
      fails++;
      $display("FAIL %s rdata addr %0d: got %h exp %h", tag, bus_addr, bus_rdata, mread(bus_addr));
    end
    if (grp_irq !== mgrp()) begin
      fails++;
      $display("FAIL %s grp_irq: got %b exp %b", tag, grp_irq, mgrp());
    end
  end

  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk); #1;
      bus_wr = 0;
      bus_addr = bus_addr + 1;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, input int n);
    @(negedge clk); #1;
    bus_wr = 0; bus_addr = a;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic done();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired (all requirements)");
    done();
  end

  initial begin
    tag = "R8";
    step(4);
    @(negedge clk); #1; rst_n = 1;
    step(6);
    tag = "R5";
    wr(3, 32'h0FFF_FFFF); rd(3, 2);
    wr(3, 32'h0); rd(3, 2);
    tag = "R1 R9 R10";
    wr(0, 32'hFFFF_FFFF); rd(0, 2);
    wr(1, 32'hFFFF_FFFF); rd(1, 2);
    wr(2, 32'hFFFF_FFFF); rd(2, 2);
    tag = "R2 R4";
    wr(0, 32'h6666_6164); rd(0, 1);
    wr(1, 32'hFF00_0602); rd(1, 1);
    wr(3, 32'h0FFF_FFFF);
    rd(3, 3);
    irq_in = '0; rd(3, 5);
    tag = "R6 R7";
    wr(2, 32'h0); step(3);
    wr(3, 32'h0FFF_FFFF); step(3);
    irq_in = '1; rd(3, 4);
    for (int g = 0; g < 4; g++) begin
      wr(2, g == 0 ? 32'h0FFF_FFF0 : g == 1 ? 32'h0FFF_F00F :
            g == 2 ? 32'h0FF0_0FFF : 32'h000F_FFFF);
      wr(3, 32'h0FFF_FFFF);
      irq_in = '0; step(4);
      irq_in = '1; step(4);
    end
    tag = "R3 R5";
    wr(2, 32'h0);
    irq_in[4] = 1; step(4);
    wr(3, 32'h0000_0010); rd(3, 3);
    wr(3, 32'h0000_0010); rd(3, 2);
    irq_in[4] = 0; step(4);
    wr(3, 32'h0000_0010); rd(3, 3);
    wr(3, 32'h0); rd(3, 2);
    tag = "R2 R5 R6 R7";
    for (int i = 0; i < 600; i++) begin
      @(negedge clk); #1;
      irq_in = 28'($urandom);
      bus_addr = 2'($urandom);
      bus_wr = ($urandom % 4) == 0;
      bus_wdata = $urandom;
    end
    @(negedge clk); #1; bus_wr = 0;
    step(4);
    done();
  end
endmodule